// File: doc/BRIEF.md
# Branch and Jump Target Resolver

This unit settles the control-flow outcome of one 32-bit instruction. It takes the instruction word, the address of that instruction and the two 64-bit source register values. For a conditional branch it rebuilds the scattered offset bits and compares the two operands as the function code selects. For either jump form it forms the target address and the return address. All results are registered, so they appear one clock after the instruction is presented.

A fetch stage or an execute stage uses the outputs to steer the program counter: a taken flag, the next address, the value to write to the destination register, and a write enable for it. Two exception flags are also registered. One marks a branch function code that has no meaning. The other marks a computed target that is not on a 4-byte boundary; in that case the address does not advance. Flushing, prediction and register storage are handled outside this unit.

Top module: `bjr_resolver`

## Requirements
- R1: Results are registered: `out_valid_o` goes high exactly one clock after a cycle with `in_valid_i` high, and low one clock after a cycle with it low. While `rst_n` is low, every output is zero.
- R2: For a branch (opcode bits [6:0] = 0x63), the 13-bit offset is assembled with offset[12] from instruction bit 31, offset[11] from bit 7, offset[10:5] from bits 30:25, offset[4:1] from bits 11:8 and offset[0] = 0. It is sign-extended from offset[12], and a taken branch targets `pc_i` plus that offset.
- R3: For JAL (opcode 0x6f), the 21-bit offset is assembled with offset[20] from bit 31, offset[19:12] from bits 19:12, offset[11] from bit 20, offset[10:1] from bits 30:21 and offset[0] = 0. It is sign-extended from offset[20], and the jump is always taken to `pc_i` plus that offset.
- R4: For JALR (opcode 0x67), the target is `rs1_val_i` plus the sign-extended 12-bit field in instruction bits 31:20, with bit 0 of the sum forced to zero. The jump is always taken.
- R5: Branch function code (bits 14:12) 0 is taken when the operands are equal; code 1 is taken when they differ.
- R6: Code 4 is taken when rs1 < rs2 as signed two's-complement values; code 5 is taken when rs1 >= rs2 signed.
- R7: Code 6 is taken when rs1 < rs2 unsigned; code 7 is taken when rs1 >= rs2 unsigned.
- R8: A branch that is not taken, and any instruction with another opcode, yields `taken_o` = 0 and `next_pc_o` = `pc_i` + 4.
- R9: JAL and JALR give `link_o` = `pc_i` + 4 and raise `rd_we_o`, with `rd_idx_o` set to instruction bits 11:7. `rd_we_o` stays low when that index is 0, for branches and other opcodes, and when the target is misaligned.
- R10: Branch codes 2 and 3 raise `illegal_o`, keep `taken_o` low and leave `next_pc_o` equal to `pc_i`.
- R11: A taken target whose bits [1:0] are not zero raises `misalign_o`, keeps `taken_o` high, leaves `next_pc_o` equal to `pc_i` and holds `rd_we_o` low. Aligned targets never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Instruction and operands are present |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction |
| rs1_val_i | input | 64 | First source operand |
| rs2_val_i | input | 64 | Second source operand |
| out_valid_o | output | 1 | Registered results are valid |
| taken_o | output | 1 | Control transfer taken |
| next_pc_o | output | 64 | Address of the next instruction |
| link_o | output | 64 | Return address for the destination register |
| rd_we_o | output | 1 | Destination register write enable |
| rd_idx_o | output | 5 | Destination register index |
| illegal_o | output | 1 | Undefined branch function code |
| misalign_o | output | 1 | Taken target not 4-byte aligned |

## Verification
Every result (taken flag, next address, link value, write enable, both exception flags) is due on the first rising edge after the instruction is driven, and it holds until the next edge. The bench drives each instruction on a falling edge, waits for one rising edge, and compares all outputs on the following falling edge with values from its own reference model. The ordering at the edge therefore never affects the result. Directed scenarios cover each comparison, offset bit position, alignment case and the x0 destination, and a randomized run mixes opcodes, offsets and operands.

// File: rtl/bjr_pkg.sv
package bjr_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned RIDX_W  = 5;

    localparam logic [6:0] OPC_BRANCH = 7'h63;
    localparam logic [6:0] OPC_JAL    = 7'h6f;
    localparam logic [6:0] OPC_JALR   = 7'h67;

    typedef enum logic [2:0] {
        CMP_EQ   = 3'd0,
        CMP_NE   = 3'd1,
        CMP_RSV2 = 3'd2,
        CMP_RSV3 = 3'd3,
        CMP_LT   = 3'd4,
        CMP_GE   = 3'd5,
        CMP_LTU  = 3'd6,
        CMP_GEU  = 3'd7
    } cmp_code_e;

    typedef enum logic [1:0] {
        FLOW_NONE,
        FLOW_BRANCH,
        FLOW_JAL,
        FLOW_JALR
    } flow_kind_e;

endpackage

// File: rtl/bjr_imm_decode.sv
module bjr_imm_decode
    import bjr_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [INSTR_W-1:0] instr_i,
    output logic [XLEN-1:0]    off_branch_o,
    output logic [XLEN-1:0]    off_jump_o,
    output logic [XLEN-1:0]    off_reg_o
);
    localparam int unsigned BW = 13;
    localparam int unsigned JW = 21;
    localparam int unsigned IW = 12;

    logic [BW-1:0] b_raw;
    logic [JW-1:0] j_raw;
    logic [IW-1:0] i_raw;

    always_comb begin
        b_raw = {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
        j_raw = {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
        i_raw = instr_i[31:20];
        off_branch_o = {{(XLEN-BW){b_raw[BW-1]}}, b_raw};
        off_jump_o   = {{(XLEN-JW){j_raw[JW-1]}}, j_raw};
        off_reg_o    = {{(XLEN-IW){i_raw[IW-1]}}, i_raw};
    end

endmodule

// File: rtl/bjr_compare.sv
module bjr_compare
    import bjr_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] lhs_i,
    input  logic [XLEN-1:0] rhs_i,
    input  cmp_code_e       code_i,
    output logic            cond_o,
    output logic            bad_code_o
);
    logic same;
    logic below_s;
    logic below_u;

    always_comb begin
        same    = (lhs_i == rhs_i);
        below_s = ($signed(lhs_i) < $signed(rhs_i));
        below_u = (lhs_i < rhs_i);
        cond_o     = 1'b0;
        bad_code_o = 1'b0;
        unique case (code_i)
            CMP_EQ:   cond_o = same;
            CMP_NE:   cond_o = !same;
            CMP_LT:   cond_o = below_s;
            CMP_GE:   cond_o = !below_s;
            CMP_LTU:  cond_o = below_u;
            CMP_GEU:  cond_o = !below_u;
            default:  bad_code_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/bjr_target_calc.sv
module bjr_target_calc #(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] offset_i,
    input  logic            clear_lsb_i,
    output logic [XLEN-1:0] target_o,
    output logic            unaligned_o
);
    logic [XLEN-1:0] sum;

    always_comb begin
        sum         = base_i + offset_i;
        target_o    = {sum[XLEN-1:1], sum[0] & !clear_lsb_i};
        unaligned_o = |target_o[ALIGN_BITS-1:0];
    end

endmodule

// File: rtl/bjr_resolver.sv
module bjr_resolver
    import bjr_pkg::*;
#(
    parameter int unsigned XLEN       = 64,
    parameter int unsigned INST_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid_i,
    input  logic [INSTR_W-1:0]   instr_i,
    input  logic [XLEN-1:0]      pc_i,
    input  logic [XLEN-1:0]      rs1_val_i,
    input  logic [XLEN-1:0]      rs2_val_i,
    output logic                 out_valid_o,
    output logic                 taken_o,
    output logic [XLEN-1:0]      next_pc_o,
    output logic [XLEN-1:0]      link_o,
    output logic                 rd_we_o,
    output logic [RIDX_W-1:0]    rd_idx_o,
    output logic                 illegal_o,
    output logic                 misalign_o
);
    localparam int unsigned ALIGN_BITS = $clog2(INST_BYTES);

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [XLEN-1:0]   next_pc;
        logic [XLEN-1:0]   link;
        logic              rd_we;
        logic [RIDX_W-1:0] rd_idx;
        logic              illegal;
        logic              misalign;
    } res_t;

    res_t res_d, res_q;

    logic [XLEN-1:0] off_branch, off_jump, off_reg;
    logic [XLEN-1:0] tgt_base, tgt_off, target;
    logic            cond, bad_code, unaligned;
    flow_kind_e      kind;
    logic [XLEN-1:0] pc_seq;

    bjr_imm_decode #(.XLEN(XLEN)) imm_i (
        .instr_i      (instr_i),
        .off_branch_o (off_branch),
        .off_jump_o   (off_jump),
        .off_reg_o    (off_reg)
    );

    bjr_compare #(.XLEN(XLEN)) cmp_i (
        .lhs_i      (rs1_val_i),
        .rhs_i      (rs2_val_i),
        .code_i     (cmp_code_e'(instr_i[14:12])),
        .cond_o     (cond),
        .bad_code_o (bad_code)
    );

    always_comb begin
        unique case (instr_i[6:0])
            OPC_BRANCH: kind = FLOW_BRANCH;
            OPC_JAL:    kind = FLOW_JAL;
            OPC_JALR:   kind = FLOW_JALR;
            default:    kind = FLOW_NONE;
        endcase
        pc_seq   = pc_i + XLEN'(INST_BYTES);
        tgt_base = (kind == FLOW_JALR) ? rs1_val_i : pc_i;
        unique case (kind)
            FLOW_BRANCH: tgt_off = off_branch;
            FLOW_JAL:    tgt_off = off_jump;
            default:     tgt_off = off_reg;
        endcase
    end

    bjr_target_calc #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) tgt_i (
        .base_i      (tgt_base),
        .offset_i    (tgt_off),
        .clear_lsb_i (kind == FLOW_JALR),
        .target_o    (target),
        .unaligned_o (unaligned)
    );

    always_comb begin
        res_d = '0;
        if (in_valid_i) begin
            res_d.valid   = 1'b1;
            res_d.next_pc = pc_seq;
            res_d.link    = pc_seq;
            res_d.rd_idx  = instr_i[11:7];
            unique case (kind)
                FLOW_BRANCH: begin
                    if (bad_code) begin
                        res_d.illegal = 1'b1;
                        res_d.next_pc = pc_i;
                    end else if (cond) begin
                        res_d.taken = 1'b1;
                        if (unaligned) begin
                            res_d.misalign = 1'b1;
                            res_d.next_pc  = pc_i;
                        end else begin
                            res_d.next_pc = target;
                        end
                    end
                end
                FLOW_JAL, FLOW_JALR: begin
                    res_d.taken = 1'b1;
                    if (unaligned) begin
                        res_d.misalign = 1'b1;
                        res_d.next_pc  = pc_i;
                    end else begin
                        res_d.next_pc = target;
                        res_d.rd_we   = (instr_i[11:7] != '0);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid_o = res_q.valid;
    assign taken_o     = res_q.taken;
    assign next_pc_o   = res_q.next_pc;
    assign link_o      = res_q.link;
    assign rd_we_o     = res_q.rd_we;
    assign rd_idx_o    = res_q.rd_idx;
    assign illegal_o   = res_q.illegal;
    assign misalign_o  = res_q.misalign;

endmodule

// File: rtl/bjr_resolver_chk.sv
module bjr_resolver_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid_i,
    input logic [XLEN-1:0] pc_i,
    input logic            out_valid_o,
    input logic            taken_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic [XLEN-1:0] link_o,
    input logic            rd_we_o,
    input logic [4:0]      rd_idx_o,
    input logic            illegal_o,
    input logic            misalign_o
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);                                          // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);                                        // R1
    AST_SEQ_WHEN_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i ##1 (out_valid_o && !taken_o && !illegal_o)
        |-> next_pc_o == $past(pc_i) + XLEN'(4));                             // R8
    AST_LINK_IS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i ##1 rd_we_o |-> link_o == $past(pc_i) + XLEN'(4));         // R9
    AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> (rd_idx_o != 5'd0) && taken_o);                           // R9
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !taken_o && !rd_we_o && !misalign_o);                   // R10
    AST_MISALIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i ##1 misalign_o |-> next_pc_o == $past(pc_i) && !rd_we_o && taken_o); // R11
    AST_TAKEN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && !misalign_o) |-> next_pc_o[1:0] == 2'b00);                // R11
endmodule

bind bjr_resolver bjr_resolver_chk #(.XLEN(XLEN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .pc_i        (pc_i),
    .out_valid_o (out_valid_o),
    .taken_o     (taken_o),
    .next_pc_o   (next_pc_o),
    .link_o      (link_o),
    .rd_we_o     (rd_we_o),
    .rd_idx_o    (rd_idx_o),
    .illegal_o   (illegal_o),
    .misalign_o  (misalign_o)
);

// File: tb/bjr_resolver_tb_top.sv
module bjr_resolver_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] pc_i = '0, rs1_val_i = '0, rs2_val_i = '0;
    logic        out_valid_o, taken_o, rd_we_o, illegal_o, misalign_o;
    logic [63:0] next_pc_o, link_o;
    logic [4:0]  rd_idx_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    bjr_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .instr_i(instr_i),
        .pc_i(pc_i), .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i),
        .out_valid_o(out_valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
        .link_o(link_o), .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o),
        .illegal_o(illegal_o), .misalign_o(misalign_o)
    );

    typedef struct packed {
        logic        valid, taken, illegal, mis, we;
        logic [4:0]  rd;
        logic [63:0] npc, link;
    } exp_t;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000) begin
            checks++; errors++;
            $display("FAIL watchdog: act=expired exp=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- encoders ----------------
    function automatic logic [31:0] enc_br(input logic [12:0] off, input logic [2:0] f3);
        return {off[12], off[10:5], 5'd7, 5'd3, f3, off[4:1], off[11], 7'h63};
    endfunction
    function automatic logic [31:0] enc_jal(input logic [20:0] off, input logic [4:0] rd);
        return {off[20], off[10:1], off[11], off[19:12], rd, 7'h6f};
    endfunction
    function automatic logic [31:0] enc_jalr(input logic [11:0] imm, input logic [4:0] rd);
        return {imm, 5'd9, 3'd0, rd, 7'h67};
    endfunction

    // ---------------- reference model ----------------
    function automatic exp_t model(input logic [31:0] ins, input logic [63:0] pc,
                                   input logic [63:0] a, input logic [63:0] b);
        exp_t e;
        logic [63:0] off, tgt;
        logic go, cf;
        e = '0;
        e.valid = 1'b1;
        e.npc = pc + 64'd4;
        e.link = pc + 64'd4;
        e.rd = ins[11:7];
        cf = 1'b0; go = 1'b0; tgt = '0;
        case (ins[6:0])
            7'h63: begin
                off = 64'($signed({ins[31], ins[7], ins[30:25], ins[11:8], 1'b0}));
                case (ins[14:12])
                    3'd0: go = (a == b);
                    3'd1: go = (a != b);
                    3'd4: go = ($signed(a) < $signed(b));
                    3'd5: go = ($signed(a) >= $signed(b));
                    3'd6: go = (a < b);
                    3'd7: go = (a >= b);
                    default: begin e.illegal = 1'b1; e.npc = pc; end
                endcase
                tgt = pc + off;
            end
            7'h6f: begin
                off = 64'($signed({ins[31], ins[19:12], ins[20], ins[30:21], 1'b0}));
                go = 1'b1; cf = 1'b1; tgt = pc + off;
            end
            7'h67: begin
                off = 64'($signed(ins[31:20]));
                go = 1'b1; cf = 1'b1; tgt = (a + off) & ~64'd1;
            end
            default: ;
        endcase
        if (go) begin
            e.taken = 1'b1;
            if (tgt[1:0] != 2'b00) begin e.mis = 1'b1; e.npc = pc; end
            else begin
                e.npc = tgt;
                e.we = cf && (ins[11:7] != 5'd0);
            end
        end
        return e;
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag, input exp_t e);
        chk(tag, "valid",    64'(out_valid_o), 64'(e.valid));
        chk(tag, "taken",    64'(taken_o),     64'(e.taken));
        chk(tag, "illegal",  64'(illegal_o),   64'(e.illegal));
        chk(tag, "misalign", 64'(misalign_o),  64'(e.mis));
        chk(tag, "rd_we",    64'(rd_we_o),     64'(e.we));
        chk(tag, "next_pc",  next_pc_o,        e.npc);
        if (e.valid) begin
            chk(tag, "rd_idx", 64'(rd_idx_o), 64'(e.rd));
            chk(tag, "link",   link_o,        e.link);
        end
    endtask

    // drive on a falling edge, results due after the next rising edge
    task automatic apply(input string tag, input logic [31:0] ins, input logic [63:0] pc,
                         input logic [63:0] a, input logic [63:0] b);
        exp_t e;
        instr_i = ins; pc_i = pc; rs1_val_i = a; rs2_val_i = b; in_valid_i = 1'b1;
        e = model(ins, pc, a, b);
        @(posedge clk); @(negedge clk);
        compare_all(tag, e);
        in_valid_i = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        @(negedge clk);
        chk("R1", "valid in reset", 64'(out_valid_o), 64'd0);
        chk("R1", "taken in reset", 64'(taken_o), 64'd0);
        chk("R1", "next_pc in reset", next_pc_o, 64'd0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1", "idle valid", 64'(out_valid_o), 64'd0);
    endtask

    task automatic t_latency;
        apply("R1", enc_br(13'd16, 3'd0), 64'h100, 64'd5, 64'd5);
        @(posedge clk); @(negedge clk);
        chk("R1", "valid drops", 64'(out_valid_o), 64'd0);
    endtask

    task automatic t_eq_ne;
        apply("R5", enc_br(13'd32, 3'd0), 64'h2000, 64'd9, 64'd9);
        chk("R5", "beq target", next_pc_o, 64'h2020);
        apply("R5", enc_br(13'd32, 3'd0), 64'h2000, 64'd9, 64'd8);
        apply("R5", enc_br(13'd32, 3'd1), 64'h2000, 64'd9, 64'd8);
        apply("R5", enc_br(13'd32, 3'd1), 64'h2000, 64'd9, 64'd9);
    endtask

    task automatic t_signed;
        apply("R6", enc_br(13'd8, 3'd4), 64'h300, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        chk("R6", "blt -1<1", 64'(taken_o), 64'd1);
        apply("R6", enc_br(13'd8, 3'd5), 64'h300, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        chk("R6", "bge -1>=1", 64'(taken_o), 64'd0);
        apply("R6", enc_br(13'd8, 3'd5), 64'h300, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        apply("R6", enc_br(13'd8, 3'd4), 64'h300, 64'd7, 64'd7);
    endtask

    task automatic t_unsigned;
        apply("R7", enc_br(13'd8, 3'd6), 64'h300, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        chk("R7", "bltu max<1", 64'(taken_o), 64'd0);
        apply("R7", enc_br(13'd8, 3'd7), 64'h300, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        chk("R7", "bgeu max>=1", 64'(taken_o), 64'd1);
        apply("R7", enc_br(13'd8, 3'd6), 64'h300, 64'd0, 64'd1);
        apply("R7", enc_br(13'd8, 3'd7), 64'h300, 64'd3, 64'd3);
    endtask

    task automatic t_branch_offset;
        apply("R2", enc_br(13'h1000, 3'd0), 64'h1000_0000, 64'd0, 64'd0);
        chk("R2", "offset -4096", next_pc_o, 64'h0FFF_F000);
        apply("R2", enc_br(13'h0800, 3'd0), 64'h1000_0000, 64'd0, 64'd0);
        chk("R2", "offset bit11", next_pc_o, 64'h1000_0800);
        apply("R2", enc_br(13'h07FC, 3'd0), 64'h1000_0000, 64'd0, 64'd0);
        chk("R2", "offset 0x7fc", next_pc_o, 64'h1000_07FC);
        apply("R2", enc_br(13'h1FFC, 3'd0), 64'h4, 64'd0, 64'd0);
        chk("R2", "offset -4 wraps", next_pc_o, 64'h0);
    endtask

    task automatic t_jal;
        apply("R3", enc_jal(21'h0FF800, 5'd1), 64'h4000, 64'd0, 64'd0);
        chk("R3", "jal +0xff800", next_pc_o, 64'h10_3800);
        chk("R9", "jal link", link_o, 64'h4004);
        chk("R9", "jal we", 64'(rd_we_o), 64'd1);
        apply("R3", enc_jal(21'h100000, 5'd5), 64'h0010_0000, 64'd0, 64'd0);
        chk("R3", "jal -1MiB", next_pc_o, 64'h0);
        apply("R9", enc_jal(21'd12, 5'd0), 64'h4000, 64'd0, 64'd0);
        chk("R9", "x0 no write", 64'(rd_we_o), 64'd0);
    endtask

    task automatic t_jalr;
        apply("R4", enc_jalr(12'd1, 5'd3), 64'h800, 64'h1003, 64'd0);
        chk("R4", "jalr lsb cleared", next_pc_o, 64'h1004);
        apply("R4", enc_jalr(12'hFF0, 5'd3), 64'h800, 64'h2000, 64'd0);
        chk("R4", "jalr -16", next_pc_o, 64'h1FF0);
        apply("R9", enc_jalr(12'd0, 5'd0), 64'h800, 64'h2000, 64'd0);
    endtask

    task automatic t_other;
        apply("R8", 32'h0010_0093, 64'h5000, 64'd1, 64'd2);
        chk("R8", "non-flow seq", next_pc_o, 64'h5004);
        chk("R9", "non-flow we", 64'(rd_we_o), 64'd0);
        apply("R8", enc_br(13'd64, 3'd1), 64'h5000, 64'd4, 64'd4);
        chk("R8", "not taken seq", next_pc_o, 64'h5004);
    endtask

    task automatic t_illegal;
        apply("R10", enc_br(13'd8, 3'd2), 64'h6000, 64'd0, 64'd0);
        chk("R10", "code2 flag", 64'(illegal_o), 64'd1);
        chk("R10", "code2 pc held", next_pc_o, 64'h6000);
        apply("R10", enc_br(13'd8, 3'd3), 64'h6000, 64'd1, 64'd0);
        chk("R10", "code3 flag", 64'(illegal_o), 64'd1);
    endtask

    task automatic t_misalign;
        apply("R11", enc_br(13'd6, 3'd0), 64'h7000, 64'd0, 64'd0);
        chk("R11", "branch +6 flag", 64'(misalign_o), 64'd1);
        chk("R11", "branch +6 pc held", next_pc_o, 64'h7000);
        apply("R11", enc_br(13'd6, 3'd1), 64'h7000, 64'd0, 64'd0);
        chk("R11", "not taken no flag", 64'(misalign_o), 64'd0);
        apply("R11", enc_jal(21'd2, 5'd1), 64'h7000, 64'd0, 64'd0);
        chk("R11", "jal no write", 64'(rd_we_o), 64'd0);
        apply("R11", enc_jalr(12'd1, 5'd1), 64'h7000, 64'h1001, 64'd0);
        chk("R11", "jalr 0x1002", 64'(misalign_o), 64'd1);
    endtask

    task automatic t_random;
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ins;
            logic [63:0] a, b, pc;
            int sel;
            sel = $urandom_range(0, 3);
            pc = {$urandom(), $urandom()} & ~64'd3;
            a = {$urandom(), $urandom()};
            b = ($urandom_range(0, 3) == 0) ? a : {$urandom(), $urandom()};
            ins = $urandom();
            case (sel)
                0: ins[6:0] = 7'h63;
                1: ins[6:0] = 7'h6f;
                2: ins[6:0] = 7'h67;
                default: ;
            endcase
            apply("R2-rand", ins, pc, a, b);
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_eq_ne();
        t_signed();
        t_unsigned();
        t_branch_offset();
        t_jal();
        t_jalr();
        t_other();
        t_illegal();
        t_misalign();
        t_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule